// File: doc/BRIEF.md
# SECDED Read Path with Correction Stall

This block sits between a 72-bit protected memory and the consumer of its 64-bit read data. On the write side a combinational encoder turns a 64-bit data word into a 72-bit stored word: seven Hamming check bits and one overall parity bit. On the read side the stored word is decoded into a syndrome and an overall parity result. The decoder decides whether the word is clean, carries one flipped bit, or is damaged beyond repair.

Clean and uncorrectable words go straight through, in the same cycle, on a valid/ready handshake. A word with a single flipped bit is taken into a small correction stage. That stage deasserts the upstream ready, flips the faulty bit in a registered step, and then offers the repaired word downstream. The correction logic therefore never lies on the zero-latency path, and it costs cycles only when an error is actually present.

Top module: `ecc_rd_path`

## Requirements
- R1: The encoded word places the seven check bits at codeword indices 1, 2, 4, 8, 16, 32 and 64. The data bits fill the other indices from 3 to 71 in ascending order, data bit 0 first. Each check bit at index 2^i is the XOR of every data bit whose index has bit i set. Index 0 makes the XOR of all 72 bits zero.
- R2: A clean read word (syndrome zero, overall parity even) gives `out_valid_o` in the same cycle as `rd_valid_i`. It carries the data field and status 2'b00 (clean).
- R3: A word with one flipped data bit is accepted and is not shown at the output for two cycles. In the cycle two clocks after acceptance the output shows the corrected data with status 2'b01 (corrected).
- R4: A single flip in a check bit or in the overall parity bit takes the same two-cycle stall. It returns the unchanged data with status 2'b01.
- R5: A word with a nonzero syndrome and even overall parity (two flipped bits) is returned in the same cycle with status 2'b10 (uncorrectable). It carries the data field as read, with no stall.
- R6: Odd overall parity with a syndrome above 71 is returned in the same cycle with status 2'b10.
- R7: While a correction is pending, `rd_ready_o` is low. The next read is accepted only in the cycle after the corrected word has been taken, which is three cycles after the faulty word was accepted when downstream is ready.
- R8: While `out_ready_i` is low, the corrected word stays valid with unchanged data and status.
- R9: For clean and uncorrectable words, `rd_ready_o` equals `out_ready_i`. Back-pressure holds the word at the input.
- R10: While `rst` is high and after its release, no output is valid until a read is presented. With no correction pending, `rd_ready_o` follows `out_ready_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_data_i | input | 64 | Data word to be encoded |
| wr_code_o | output | 72 | Encoded word to be stored |
| rd_valid_i | input | 1 | Read word present |
| rd_ready_o | output | 1 | Read word can be taken this cycle |
| rd_code_i | input | 72 | Stored word as read from memory |
| out_valid_o | output | 1 | Result word valid |
| out_ready_i | input | 1 | Consumer takes the result |
| out_data_o | output | 64 | Result data |
| out_status_o | output | 2 | 00 clean, 01 corrected, 10 uncorrectable |

## Verification
Clean and uncorrectable words are due in the very cycle they are accepted. A corrected word is due two cycles after its acceptance cycle, plus any cycles the consumer holds ready low. The driver records the cycle of acceptance and pushes the expected data, status and due cycle into a scoreboard. The monitor samples mid-cycle, away from the clock edge, and compares the cycle of each handshake against that stamp. Stall and hold behaviour are also probed directly by reading `rd_ready_o` and the held output in each cycle of the stall.

// File: rtl/ecc_rd_pkg.sv
`timescale 1ns/1ps
package ecc_rd_pkg;

    // Data width of one protected granule.
    localparam int DATA_W = 64;

    // Smallest number of Hamming check bits covering DATA_W data bits.
    function automatic int calc_par_w(input int dw);
        int p;
        p = 1;
        while ((1 << p) < dw + p + 1) p++;
        return p;
    endfunction

    localparam int PAR_W = calc_par_w(DATA_W);   // Hamming check bits
    localparam int POS_N = DATA_W + PAR_W;       // highest Hamming index
    localparam int CW_W  = POS_N + 1;            // index 0 holds overall parity
    localparam int SYN_W = PAR_W;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [CW_W-1:0]   code_t;
    typedef logic [SYN_W-1:0]  syn_t;

    typedef enum logic [1:0] {
        ST_CLEAN  = 2'b00,
        ST_FIXED  = 2'b01,
        ST_UNCORR = 2'b10
    } rd_status_e;

    typedef enum logic [1:0] {
        K_NONE   = 2'b00,
        K_SINGLE = 2'b01,
        K_MULTI  = 2'b10
    } err_kind_e;

    typedef struct packed {
        err_kind_e kind;
        syn_t      syn;
        data_t     data;
    } chk_result_t;

    typedef enum logic [1:0] {
        FX_IDLE = 2'b00,
        FX_FLIP = 2'b01,
        FX_SEND = 2'b10
    } fix_state_e;

    function automatic logic is_pow2(input int v);
        return (v & (v - 1)) == 0;
    endfunction

    // Scatter data bits over the non-power-of-two indices.
    function automatic code_t place_data(input data_t d);
        code_t c;
        int    k;
        c = '0;
        k = 0;
        for (int pos = 1; pos <= POS_N; pos++) begin
            if (!is_pow2(pos)) begin
                c[pos] = d[k];
                k++;
            end
        end
        return c;
    endfunction

    // Gather data bits back from a codeword.
    function automatic data_t pick_data(input code_t c);
        data_t d;
        int    k;
        d = '0;
        k = 0;
        for (int pos = 1; pos <= POS_N; pos++) begin
            if (!is_pow2(pos)) begin
                d[k] = c[pos];
                k++;
            end
        end
        return d;
    endfunction

    // XOR of the indices of all set bits in the Hamming part.
    function automatic syn_t syndrome(input code_t c);
        syn_t s;
        s = '0;
        for (int pos = 1; pos <= POS_N; pos++) begin
            if (c[pos]) s = s ^ syn_t'(pos);
        end
        return s;
    endfunction

    function automatic code_t encode(input data_t d);
        code_t c;
        syn_t  s;
        c = place_data(d);
        s = syndrome(c);
        for (int i = 0; i < PAR_W; i++) begin
            c[1 << i] = s[i];
        end
        c[0] = ^c[CW_W-1:1];
        return c;
    endfunction

endpackage

// File: rtl/ecc_rd_enc.sv
`timescale 1ns/1ps
module ecc_rd_enc
    import ecc_rd_pkg::*;
(
    input  data_t data_i,
    output code_t code_o
);
    always_comb begin
        code_o = encode(data_i);
    end
endmodule

// File: rtl/ecc_rd_classify.sv
`timescale 1ns/1ps
module ecc_rd_classify
    import ecc_rd_pkg::*;
(
    input  code_t       cw_i,
    output chk_result_t res_o
);
    syn_t syn;
    logic par_odd;

    always_comb begin
        syn     = syndrome(cw_i);
        par_odd = ^cw_i;
        res_o.syn  = syn;
        res_o.data = pick_data(cw_i);
        if (!par_odd) begin
            res_o.kind = (syn == '0) ? K_NONE : K_MULTI;
        end else begin
            // Odd parity: one flip, unless the syndrome names no real index.
            res_o.kind = (syn <= syn_t'(POS_N)) ? K_SINGLE : K_MULTI;
        end
    end
endmodule

// File: rtl/ecc_rd_fix.sv
`timescale 1ns/1ps
module ecc_rd_fix
    import ecc_rd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load_i,
    input  code_t word_i,
    input  syn_t  syn_i,
    input  logic  take_i,
    output logic  busy_o,
    output logic  send_o,
    output data_t data_o
);
    fix_state_e state_q;
    code_t      held_cw_q;
    syn_t       held_syn_q;
    data_t      fixed_q;
    code_t      flip_mask;

    // Syndrome zero with odd parity points at index 0, the parity bit.
    assign flip_mask = code_t'(1) << held_syn_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= FX_IDLE;
            held_cw_q  <= '0;
            held_syn_q <= '0;
            fixed_q    <= '0;
        end else begin
            case (state_q)
                FX_IDLE: begin
                    if (load_i) begin
                        held_cw_q  <= word_i;
                        held_syn_q <= syn_i;
                        state_q    <= FX_FLIP;
                    end
                end
                FX_FLIP: begin
                    fixed_q <= pick_data(held_cw_q ^ flip_mask);
                    state_q <= FX_SEND;
                end
                FX_SEND: begin
                    if (take_i) state_q <= FX_IDLE;
                end
                default: state_q <= FX_IDLE;
            endcase
        end
    end

    assign busy_o = (state_q != FX_IDLE);
    assign send_o = (state_q == FX_SEND);
    assign data_o = fixed_q;
endmodule

// File: rtl/ecc_rd_path.sv
`timescale 1ns/1ps
module ecc_rd_path
    import ecc_rd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [63:0] wr_data_i,
    output logic [71:0] wr_code_o,
    input  logic        rd_valid_i,
    output logic        rd_ready_o,
    input  logic [71:0] rd_code_i,
    output logic        out_valid_o,
    input  logic        out_ready_i,
    output logic [63:0] out_data_o,
    output logic [1:0]  out_status_o
);
    chk_result_t chk;
    logic        fix_busy;
    logic        fix_send;
    data_t       fix_data;
    logic        is_single;
    logic        load;
    rd_status_e  status;

    ecc_rd_enc u_enc (
        .data_i (wr_data_i),
        .code_o (wr_code_o)
    );

    ecc_rd_classify u_cls (
        .cw_i  (rd_code_i),
        .res_o (chk)
    );

    assign is_single = (chk.kind == K_SINGLE);
    assign load      = !fix_busy && rd_valid_i && is_single;

    ecc_rd_fix u_fix (
        .clk    (clk),
        .rst    (rst),
        .load_i (load),
        .word_i (rd_code_i),
        .syn_i  (chk.syn),
        .take_i (out_ready_i),
        .busy_o (fix_busy),
        .send_o (fix_send),
        .data_o (fix_data)
    );

    always_comb begin
        rd_ready_o  = !fix_busy && (is_single || out_ready_i);
        out_valid_o = fix_send || (!fix_busy && rd_valid_i && !is_single);
        if (fix_send) begin
            out_data_o = fix_data;
            status     = ST_FIXED;
        end else begin
            out_data_o = chk.data;
            status     = (chk.kind == K_MULTI) ? ST_UNCORR : ST_CLEAN;
        end
        out_status_o = status;
    end
endmodule

// File: rtl/ecc_rd_path_chk.sv
`timescale 1ns/1ps
module ecc_rd_path_chk
    import ecc_rd_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [63:0] wr_data_i,
    input logic [71:0] wr_code_o,
    input logic        rd_valid_i,
    input logic        rd_ready_o,
    input logic [71:0] rd_code_i,
    input logic        out_valid_o,
    input logic        out_ready_i,
    input logic [63:0] out_data_o,
    input logic [1:0]  out_status_o
);
    logic accept_hidden;
    assign accept_hidden = rd_valid_i && rd_ready_o && !out_valid_o;

    a_r1_even_parity: assert property (@(posedge clk) disable iff (rst)
        (^wr_code_o) == 1'b0);

    a_r3_stall_gap: assert property (@(posedge clk) disable iff (rst)
        accept_hidden |=> (!out_valid_o && !rd_ready_o));

    a_r3_fixed_due: assert property (@(posedge clk) disable iff (rst)
        accept_hidden |-> ##2 (out_valid_o && out_status_o == 2'b01));

    a_r5_uncorr_no_stall: assert property (@(posedge clk) disable iff (rst)
        (rd_valid_i && rd_ready_o && out_status_o == 2'b10) |-> out_valid_o);

    a_r7_no_accept_pending: assert property (@(posedge clk) disable iff (rst)
        (out_valid_o && out_status_o == 2'b01) |-> !rd_ready_o);

    a_r8_hold_fixed: assert property (@(posedge clk) disable iff (rst)
        (out_valid_o && out_status_o == 2'b01 && !out_ready_i)
        |=> (out_valid_o && out_status_o == 2'b01 && $stable(out_data_o)));

    a_r9_bypass_ready: assert property (@(posedge clk) disable iff (rst)
        (rd_valid_i && out_valid_o && out_status_o != 2'b01)
        |-> (rd_ready_o == out_ready_i));

    a_r10_reset_idle: assert property (@(posedge clk)
        rst |=> !(out_valid_o && out_status_o == 2'b01));
endmodule

bind ecc_rd_path ecc_rd_path_chk chk_i (.*);

// File: tb/ecc_rd_path_tb_top.sv
`timescale 1ns/1ps
module ecc_rd_path_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] wr_data = '0;
    logic [71:0] wr_code;
    logic        rd_valid = 1'b0;
    logic        rd_ready;
    logic [71:0] rd_code = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [63:0] out_data;
    logic [1:0]  out_status;

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;
    int hold_extra = 0;
    bit finished = 0;

    typedef struct {
        logic [63:0] d;
        logic [1:0]  st;
        int          due;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ecc_rd_path dut_i (
        .clk          (clk),
        .rst          (rst),
        .wr_data_i    (wr_data),
        .wr_code_o    (wr_code),
        .rd_valid_i   (rd_valid),
        .rd_ready_o   (rd_ready),
        .rd_code_i    (rd_code),
        .out_valid_o  (out_valid),
        .out_ready_i  (out_ready),
        .out_data_o   (out_data),
        .out_status_o (out_status)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [71:0] act, input logic [71:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit is_chk_pos(input int p);
        return p == 1 || p == 2 || p == 4 || p == 8 || p == 16 || p == 32 || p == 64;
    endfunction

    // Model of R1: per-check-bit masks over the data positions.
    function automatic logic [71:0] model_enc(input logic [63:0] d);
        logic [71:0] w;
        logic        x;
        int          k;
        w = '0;
        k = 0;
        for (int p = 1; p <= 71; p++) begin
            if (!is_chk_pos(p)) begin
                w[p] = d[k];
                k++;
            end
        end
        for (int b = 0; b < 7; b++) begin
            x = 1'b0;
            for (int p = 3; p <= 71; p++) begin
                if (!is_chk_pos(p) && p[b]) x = x ^ w[p];
            end
            w[1 << b] = x;
        end
        w[0] = ^w[71:1];
        return w;
    endfunction

    function automatic logic [63:0] model_data(input logic [71:0] w);
        logic [63:0] d;
        int          k;
        d = '0;
        k = 0;
        for (int p = 1; p <= 71; p++) begin
            if (!is_chk_pos(p)) begin
                d[k] = w[p];
                k++;
            end
        end
        return d;
    endfunction

    // Called at a falling edge; returns the cycle in which the word was taken.
    task automatic send(input logic [71:0] w, input logic [63:0] ed,
                        input logic [1:0] es, input int lat,
                        input string tag, output int acc);
        rd_code  = w;
        rd_valid = 1'b1;
        #1;
        while (!rd_ready) begin
            @(negedge clk);
            #1;
        end
        acc = cyc;
        sb.push_back('{d: ed, st: es, due: cyc + lat + hold_extra, tag: tag});
        @(negedge clk);
        rd_valid = 1'b0;
    endtask

    // Scoreboard monitor: mid-cycle, compares each handshake.
    always @(negedge clk) begin
        exp_t e;
        #2;
        if (!rst && !finished && out_valid && out_ready) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R2 unexpected output", {8'h0, out_data}, '0);
            end else begin
                e = sb.pop_front();
                chk(out_data == e.d, {e.tag, " data"}, {8'h0, out_data}, {8'h0, e.d});
                chk(out_status == e.st, {e.tag, " status"}, {70'h0, out_status}, {70'h0, e.st});
                chk(cyc == e.due, {e.tag, " cycle"}, 72'(cyc), 72'(e.due));
            end
        end
    end

    initial begin
        #100000;
        nerr++;
        nchk++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        logic [63:0] pats [5];
        logic [71:0] w;
        int a1;
        int a2;
        pats[0] = 64'h0;
        pats[1] = 64'hFFFF_FFFF_FFFF_FFFF;
        pats[2] = 64'h0123_4567_89AB_CDEF;
        pats[3] = 64'hA5A5_5A5A_C3C3_3C3C;
        pats[4] = 64'h8000_0000_0000_0001;

        // R10: reset state
        repeat (3) @(negedge clk);
        #1;
        chk(out_valid == 1'b0, "R10 valid in reset", 72'(out_valid), 72'h0);
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk(out_valid == 1'b0, "R10 valid after reset", 72'(out_valid), 72'h0);
        chk(rd_ready == 1'b1, "R10 ready after reset", 72'(rd_ready), 72'h1);

        // R1: encoder layout
        for (int i = 0; i < 5; i++) begin
            wr_data = pats[i];
            #1;
            chk(wr_code == model_enc(pats[i]), "R1 encode", wr_code, model_enc(pats[i]));
        end
        @(negedge clk);

        // R2: clean words
        for (int i = 0; i < 5; i++) begin
            send(model_enc(pats[i]), pats[i], 2'b00, 0, "R2 clean", a1);
        end

        // R3: single data-bit flips
        begin
            int fp [4];
            fp[0] = 3; fp[1] = 5; fp[2] = 37; fp[3] = 71;
            for (int i = 0; i < 4; i++) begin
                w = model_enc(pats[(i + 1) % 5]);
                w[fp[i]] = ~w[fp[i]];
                send(w, pats[(i + 1) % 5], 2'b01, 2, "R3 single data", a1);
                repeat (2) @(negedge clk);
            end
        end

        // R4: flips in check bits and in the overall parity bit
        begin
            int cp [3];
            cp[0] = 1; cp[1] = 64; cp[2] = 0;
            for (int i = 0; i < 3; i++) begin
                w = model_enc(pats[2]);
                w[cp[i]] = ~w[cp[i]];
                send(w, pats[2], 2'b01, 2, "R4 single check", a1);
                repeat (2) @(negedge clk);
            end
        end

        // R5: double flips
        w = model_enc(pats[3]);
        w[3] = ~w[3];
        w[10] = ~w[10];
        send(w, model_data(w), 2'b10, 0, "R5 double", a1);
        w = model_enc(pats[1]);
        w[0] = ~w[0];
        w[50] = ~w[50];
        send(w, model_data(w), 2'b10, 0, "R5 double", a1);

        // R6: odd parity, syndrome 64^8^1 = 73 beyond index 71
        w = model_enc(pats[2]);
        w[64] = ~w[64];
        w[8] = ~w[8];
        w[1] = ~w[1];
        send(w, model_data(w), 2'b10, 0, "R6 out of range", a1);

        // R7: back-to-back, next read waits for the corrected handoff
        w = model_enc(pats[4]);
        w[20] = ~w[20];
        send(w, pats[4], 2'b01, 2, "R7 single", a1);
        #1;
        chk(rd_ready == 1'b0, "R7 ready during stall", 72'(rd_ready), 72'h0);
        @(negedge clk);
        send(model_enc(pats[3]), pats[3], 2'b00, 0, "R7 follow", a2);
        chk(a2 == a1 + 3, "R7 accept cycle", 72'(a2), 72'(a1 + 3));

        // R8: hold corrected word under back-pressure
        out_ready = 1'b0;
        hold_extra = 3;
        w = model_enc(pats[2]);
        w[44] = ~w[44];
        send(w, pats[2], 2'b01, 2, "R8 held", a1);
        hold_extra = 0;
        @(negedge clk);
        #1;
        chk(out_valid && out_status == 2'b01 && out_data == pats[2], "R8 held start",
            {8'h0, out_data}, {8'h0, pats[2]});
        repeat (2) begin
            @(negedge clk);
            #1;
            chk(out_valid && out_status == 2'b01 && out_data == pats[2], "R8 held",
                {8'h0, out_data}, {8'h0, pats[2]});
            chk(rd_ready == 1'b0, "R7 ready while held", 72'(rd_ready), 72'h0);
        end
        @(negedge clk);
        out_ready = 1'b1;
        @(negedge clk);

        // R9: back-pressure on a clean word
        out_ready = 1'b0;
        rd_code = model_enc(pats[1]);
        rd_valid = 1'b1;
        repeat (2) begin
            #1;
            chk(rd_ready == 1'b0, "R9 ready follows", 72'(rd_ready), 72'h0);
            chk(out_valid && out_status == 2'b00, "R9 valid offered", 72'(out_valid), 72'h1);
            @(negedge clk);
        end
        out_ready = 1'b1;
        send(model_enc(pats[1]), pats[1], 2'b00, 0, "R9 released", a1);

        repeat (4) @(negedge clk);
        chk(sb.size() == 0, "R3 scoreboard drained", 72'(sb.size()), 72'h0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule